// File: doc/BRIEF.md
# Two-Bit Branch Direction Table

This block predicts whether a branch at the current fetch address will be taken. It keeps one two-bit hysteresis counter per slot. A slot is chosen by the fetch address with its byte-offset bits removed. The prediction is read combinationally from the fetch PC in the same cycle. When a branch later resolves, the pipeline sends back the slot index it carried along with the actual outcome, and the counter at that slot moves one step. There are no tags, so branches whose addresses share the same low bits use the same counter. This can cost accuracy but never breaks correctness.

The counter changes direction only after two wrong outcomes in a row when it starts from a strong state. As a result, a loop-closing branch mispredicts only once per loop exit, and the predictor does not mispredict when the loop is entered again. Every slot returns to a reset state chosen by a parameter. The default is weak taken.

Top module: `bdir_table`

## Requirements
- R1: The slot index is `fetch_pc[IDX_W+1:2]`. PC bits [1:0] and all bits above the index field do not affect which slot is read.
- R2: `fetch_taken` is the upper bit of the selected counter. Encoding: 2'b11 strong taken, 2'b10 weak taken, 2'b01 weak not-taken, 2'b00 strong not-taken.
- R3: After reset, every slot holds `INIT_STATE`. The default is 2'b10, so every address predicts taken. With `INIT_STATE` = 2'b00, every address predicts not-taken.
- R4: An update with `upd_taken`=1 moves a slot 00→01, 01→11 and 10→11, and leaves 11 unchanged.
- R5: An update with `upd_taken`=0 moves a slot 11→10, 10→00 and 01→00, and leaves 00 unchanged.
- R6: From a strong state, the predicted direction flips only after two consecutive opposite outcomes.
- R7: An update takes effect at the clock edge. A fetch of the same slot in the cycle of the update returns the old prediction, and a fetch in the next cycle returns the new one.
- R8: An update changes only the slot it names. PCs that differ only above the index field share that slot.
- R9: While `upd_valid` is 0, `upd_idx` and `upd_taken` change no slot.
- R10: A loop branch taken nine times and then not taken once, repeated, is predicted correctly on every taken pass, including the first pass after re-entry. It mispredicts only at each loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_pc | input | PC_W | Fetch address to predict |
| fetch_taken | output | 1 | Predicted direction for `fetch_pc` (1 = taken) |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_idx | input | IDX_W | Slot index of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
Only one bit of each counter reaches the ports, so a wrong weak-versus-strong state cannot be seen at once. It shows up one or two updates later, when the prediction flips too early or too late. The bench therefore drives short outcome sequences on chosen slots and checks the prediction after every step. Each sequence is built so that a single wrong transition changes at least one later prediction. An update written to the wrong slot shows up at the first fetch of either that slot or its neighbour. The loop pattern checks over several iterations that the hysteresis absorbs the exit outcome.

// File: rtl/bht_pkg.sv
`timescale 1ns/1ps
package bht_pkg;
  typedef enum logic [1:0] {
    ST_SNT = 2'b00,
    ST_WNT = 2'b01,
    ST_WT  = 2'b10,
    ST_STK = 2'b11
  } bht_state_e;
endpackage

// File: rtl/bht_rst_sync.sv
`timescale 1ns/1ps
module bht_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bht_index.sv
`timescale 1ns/1ps
module bht_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 11,
  parameter int ALIGN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[ALIGN_W +: IDX_W];
endmodule

// File: rtl/bht_update.sv
`timescale 1ns/1ps
module bht_update #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  logic [1:0]       cur_state,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [1:0]       wr_data
);
  import bht_pkg::*;

  logic [1:0] nxt;

  always_comb begin
    nxt = cur_state;
    unique case (bht_state_e'(cur_state))
      ST_SNT: nxt = upd_taken ? ST_WNT : ST_SNT;
      ST_WNT: nxt = upd_taken ? ST_STK : ST_SNT;
      ST_WT:  nxt = upd_taken ? ST_STK : ST_SNT;
      ST_STK: nxt = upd_taken ? ST_STK : ST_WT;
      default: nxt = cur_state;
    endcase
  end

  assign wr_en   = upd_valid;
  assign wr_idx  = upd_idx;
  assign wr_data = nxt;

  // R4
  taken_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |-> ((nxt > cur_state) || (cur_state == ST_STK && nxt == ST_STK)));

  // R5
  nottaken_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |-> ((nxt < cur_state) || (cur_state == ST_SNT && nxt == ST_SNT)));

  // R6
  strong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (cur_state == ST_STK || cur_state == ST_SNT)) |-> (nxt[1] == cur_state[1]));
endmodule

// File: rtl/bht_table.sv
`timescale 1ns/1ps
module bht_table #(
  parameter int         IDX_W      = 11,
  parameter logic [1:0] INIT_STATE = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [1:0]       rd_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [1:0]       rd_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic       slot_en;
    logic [1:0] slot_q;
    assign slot_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= INIT_STATE;
      else if (slot_en) slot_q <= wr_data;
    end
    assign ent[i] = slot_q;
  end

  assign rd_a = ent[rd_idx_a];
  assign rd_b = ent[rd_idx_b];

  logic             chk_v;
  logic [IDX_W-1:0] chk_idx;
  logic [1:0]       chk_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v    <= 1'b0;
      chk_idx  <= '0;
      chk_data <= '0;
    end else begin
      chk_v    <= wr_en;
      chk_idx  <= wr_idx;
      chk_data <= wr_data;
    end
  end

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> (ent[chk_idx] == chk_data));
endmodule

// File: rtl/bdir_table.sv
`timescale 1ns/1ps
module bdir_table #(
  parameter int         PC_W       = 32,
  parameter int         IDX_W      = 11,
  parameter logic [1:0] INIT_STATE = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_taken,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int ALIGN_W = 2;

  logic             rst_int_n;
  logic [IDX_W-1:0] fetch_idx;
  logic [1:0]       fetch_state;
  logic [1:0]       upd_state;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_data;

  bht_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_idx (
    .pc(fetch_pc), .idx(fetch_idx)
  );

  bht_table #(.IDX_W(IDX_W), .INIT_STATE(INIT_STATE)) u_tab (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(fetch_idx), .rd_a(fetch_state),
    .rd_idx_b(upd_idx), .rd_b(upd_state)
  );

  bht_update #(.IDX_W(IDX_W)) u_upd (
    .clk(clk), .rst_n(rst_int_n),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
    .cur_state(upd_state),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  assign fetch_taken = fetch_state[1];

  // R3
  reset_init_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (fetch_taken == INIT_STATE[1]));

  // R7
  same_slot_new_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_valid && fetch_idx == upd_idx) |=>
      ((fetch_idx != $past(fetch_idx)) || (fetch_taken == $past(wr_data[1]))));
endmodule

// File: tb/tb_bdir_table.sv
`timescale 1ns/1ps
module tb_bdir_table;
  localparam int PC_W  = 32;
  localparam int IDX_W = 11;

  logic             clk;
  logic             rst_n;
  logic [PC_W-1:0]  fetch_pc;
  logic             upd_valid;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_taken;
  logic             pred_warm;
  logic             pred_cold;

  bdir_table #(.PC_W(PC_W), .IDX_W(IDX_W), .INIT_STATE(2'b10)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(pred_warm),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken)
  );

  bdir_table #(.PC_W(PC_W), .IDX_W(IDX_W), .INIT_STATE(2'b00)) dut_cold (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(pred_cold),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit    which;
    bit    exp;
    string tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      smp;
  int        n_run  = 0;
  int        n_fail = 0;

  always @(smp) begin
    while (exp_q.size() > 0) begin
      exp_item_t it;
      logic act;
      it = exp_q.pop_front();
      act = it.which ? pred_cold : pred_warm;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [PC_W-1:0] pc_of(input int idx, input int low, input int high);
    return PC_W'((high << (IDX_W + 2)) | (idx << 2) | low);
  endfunction

  task automatic chk(input bit which, input logic [PC_W-1:0] pc, input bit exp, input string tag);
    exp_item_t it;
    fetch_pc = pc;
    #1;
    it.which = which; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    ->smp;
    #0;
  endtask

  task automatic do_upd(input int idx, input bit tk, input bit v = 1'b1);
    @(negedge clk);
    upd_valid = v;
    upd_idx   = IDX_W'(idx);
    upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_pc = '0; upd_valid = 1'b0; upd_idx = '0; upd_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 / R2: reset contents predict per INIT_STATE upper bit
    chk(0, pc_of(0, 0, 0), 1'b1, "R3 warm slot 0");
    chk(0, pc_of(2047, 0, 0), 1'b1, "R3 warm last slot");
    chk(1, pc_of(0, 0, 0), 1'b0, "R3 cold slot 0");
    chk(1, pc_of(1234, 0, 0), 1'b0, "R2 cold weak/strong NT predicts 0");

    // R1 / R8: index field, offset bits, aliasing, neighbour untouched
    do_upd(5, 1'b0);
    do_upd(5, 1'b0);
    chk(0, pc_of(5, 3, 0), 1'b0, "R1 offset bits ignored");
    chk(0, pc_of(5, 0, 0), 1'b0, "R1 slot 5 updated");
    chk(0, pc_of(5, 0, 9), 1'b0, "R8 high-bit alias shares slot");
    chk(0, pc_of(6, 0, 0), 1'b1, "R8 neighbour slot unchanged");
    chk(0, pc_of(4, 2, 0), 1'b1, "R8 lower neighbour unchanged");

    // R4 / R5 on cold instance slot 9 (starts 00)
    do_upd(9, 1'b1); chk(1, pc_of(9, 0, 0), 1'b0, "R4 00->01");
    do_upd(9, 1'b1); chk(1, pc_of(9, 0, 0), 1'b1, "R4 01->11");
    do_upd(9, 1'b1); chk(1, pc_of(9, 0, 0), 1'b1, "R4 11 saturates");
    do_upd(9, 1'b0); chk(1, pc_of(9, 0, 0), 1'b1, "R5 11->10");
    do_upd(9, 1'b0); chk(1, pc_of(9, 0, 0), 1'b0, "R5 10->00");
    do_upd(9, 1'b0); chk(1, pc_of(9, 0, 0), 1'b0, "R5 00 saturates");
    do_upd(9, 1'b1); chk(1, pc_of(9, 0, 0), 1'b0, "R4 00->01 again");
    do_upd(9, 1'b0); chk(1, pc_of(9, 0, 0), 1'b0, "R5 01->00");
    do_upd(9, 1'b1); chk(1, pc_of(9, 0, 0), 1'b0, "R5 01->00 confirmed (01)");
    do_upd(9, 1'b1); chk(1, pc_of(9, 0, 0), 1'b1, "R4 01->11 after");

    // R4 / R6 on warm slot 20 (starts 10)
    do_upd(20, 1'b1); chk(0, pc_of(20, 0, 0), 1'b1, "R4 10->11");
    do_upd(20, 1'b0); chk(0, pc_of(20, 0, 0), 1'b1, "R6 one miss from strong keeps direction");
    do_upd(20, 1'b0); chk(0, pc_of(20, 0, 0), 1'b0, "R6 second miss flips");

    // R9: updates without valid do nothing
    do_upd(40, 1'b0, 1'b0);
    do_upd(40, 1'b0, 1'b0);
    chk(0, pc_of(40, 0, 0), 1'b1, "R9 invalid update ignored");

    // R7: same-cycle read returns old, next cycle new
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = IDX_W'(50); upd_taken = 1'b0;
    chk(0, pc_of(50, 0, 0), 1'b1, "R7 same-cycle old value");
    @(negedge clk);
    upd_valid = 1'b0;
    chk(0, pc_of(50, 0, 0), 1'b0, "R7 next-cycle new value");

    // R10: loop branch pattern T x9, N x1, five iterations on warm slot 100
    begin
      int miss_total;
      int reentry_miss;
      int taken_miss;
      miss_total = 0; reentry_miss = 0; taken_miss = 0;
      for (int it = 0; it < 5; it++) begin
        for (int k = 0; k < 10; k++) begin
          bit tk;
          tk = (k != 9);
          fetch_pc = pc_of(100, 0, 0);
          #1;
          if (pred_warm !== tk) begin
            miss_total++;
            if (tk) taken_miss++;
            if (k == 0 && it > 0) reentry_miss++;
          end
          do_upd(100, tk);
        end
      end
      check_int(miss_total, 5, "R10 one miss per loop exit");
      check_int(taken_miss, 0, "R10 taken passes all correct");
      check_int(reentry_miss, 0, "R10 re-entry predicted correctly");
    end

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule